// File: doc/BRIEF.md
# Lane-Partitioned Integer Vector ALU

This block treats each of its two 64-bit operands as a vector of independent unsigned integer lanes. One request runs a single operation on every lane at once. The lanes are eight 8-bit, four 16-bit or two 32-bit fields. The operations are wrap-around add, wrap-around subtract, left shift, logical right shift and arithmetic right shift.

The block has one segmented adder and one segmented shifter. A run-time lane mask cuts both at the lane edges. No carry and no shifted bit ever passes from one lane into the next, and the logic holds no separate copy for each lane width. A request is a pulse on `in_valid` together with the operands, the lane mode, the opcode and the shift count. One clock edge later the result appears in a register, with `out_valid` high. An unsupported mode or opcode gives an all-zero result and raises `out_error`.

Top module: `simd_packed_alu`

## Requirements
- R1: Lane mode 2'b00 selects eight 8-bit lanes, where lane i is bits [8i+7:8i]. Opcode 3'd0 (add) gives lane i of the result as (a_i + b_i) mod 2^8.
- R2: Lane mode 2'b01 selects four 16-bit lanes and lane mode 2'b10 selects two 32-bit lanes. For add, the carry out of each lane is dropped and never reaches the lane above.
- R3: Opcode 3'd1 (subtract) gives each lane as (a_i - b_i) mod 2^W, where W is the lane width. A borrow never crosses into the neighbouring lane.
- R4: Opcode 3'd2 (left shift) shifts each lane of a left by the shift count. Zeros fill from the lane's low end, and bits shifted out of the lane top are lost.
- R5: Opcode 3'd3 (logical right shift) shifts each lane of a right by the shift count. Zeros fill from the lane's top.
- R6: Opcode 3'd4 (arithmetic right shift) shifts each lane of a right by the shift count. Copies of that lane's own top bit fill from the lane's top.
- R7: The 6-bit shift count applies to every lane. A count equal to or above W gives 0 for left and logical right shifts, and gives all copies of the lane's top bit for arithmetic right shift.
- R8: Lane mode 2'b11 or an opcode of 3'd5 to 3'd7 gives out_result of zero and out_error of 1. Any supported request gives out_error of 0.
- R9: The result of a request with in_valid high appears on out_result on the first rising edge after the request. out_valid equals in_valid delayed by exactly one cycle.
- R10: While in_valid is low, out_result and out_error keep their values, whatever the other inputs do.
- R11: An active-low asynchronous reset clears out_valid, out_result and out_error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 64 | First operand, also the value that is shifted |
| opnd_b | input | 64 | Second operand for add and subtract |
| lane_mode | input | 2 | 00 = 8-bit lanes, 01 = 16-bit, 10 = 32-bit, 11 = reserved |
| op_code | input | 3 | 0 add, 1 sub, 2 shl, 3 shr, 4 sar, 5 to 7 reserved |
| shamt | input | 6 | Shift count, the same for every lane |
| out_valid | output | 1 | High one cycle after an accepted request |
| out_result | output | 64 | Registered lane-wise result |
| out_error | output | 1 | Registered flag for an unsupported mode or opcode |

## Verification
Each request is a single clock edge, so every result, error flag and valid pulse is due at that first rising edge. Nothing arrives later. The bench sets the inputs at a falling edge and reads the outputs at the next falling edge. The one edge between them is the only edge that can have loaded the register. The bench then takes in_valid low and, one more falling edge later, checks that out_valid has dropped and that the result is unchanged. This proves the register only loads on a request.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [1:0] {
    LM_B8  = 2'b00,
    LM_B16 = 2'b01,
    LM_B32 = 2'b10,
    LM_RSV = 2'b11
  } lane_mode_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_SHL = 3'd2,
    OP_SHR = 3'd3,
    OP_SAR = 3'd4
  } alu_op_e;

  // Lane width in bits for a supported mode; the reserved mode maps to chunk width.
  function automatic int lane_bits(input logic [1:0] mode, input int chunk_w);
    if (mode == LM_RSV) return chunk_w;
    return chunk_w << mode;
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    return op <= OP_SAR;
  endfunction

endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  localparam int NCHUNK = DATA_W / CHUNK_W,
  localparam int LW_W   = $clog2(DATA_W) + 1
) (
  input  logic [1:0]        lane_mode,
  input  logic [2:0]        op_code,
  output logic [NCHUNK-1:0] lane_start,
  output logic [LW_W-1:0]   lane_w,
  output logic              req_err
);

  logic mode_bad;
  assign mode_bad = (lane_mode == LM_RSV);
  assign req_err  = mode_bad | ~op_known(op_code);
  assign lane_w   = LW_W'(lane_bits(lane_mode, CHUNK_W));

  // A chunk opens a lane when its index is a multiple of the lane size in chunks.
  for (genvar k = 0; k < NCHUNK; k++) begin : g_start
    always_comb begin
      unique case (lane_mode)
        LM_B16:  lane_start[k] = (k % 2) == 0;
        LM_B32:  lane_start[k] = (k % 4) == 0;
        default: lane_start[k] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  localparam int NCHUNK = DATA_W / CHUNK_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic [NCHUNK-1:0] lane_start,
  output logic [DATA_W-1:0] sum
);

  logic [NCHUNK:0] carry;
  logic            unused_top_carry;

  assign carry[0]         = sub;
  assign unused_top_carry = carry[NCHUNK];

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    logic [CHUNK_W-1:0] bx;
    logic               cin;
    logic [CHUNK_W:0]   t;
    assign bx  = b[k*CHUNK_W +: CHUNK_W] ^ {CHUNK_W{sub}};
    // At a lane edge the incoming carry is replaced by the lane's own carry-in.
    assign cin = lane_start[k] ? sub : carry[k];
    assign t   = {1'b0, a[k*CHUNK_W +: CHUNK_W]} + {1'b0, bx} + {{CHUNK_W{1'b0}}, cin};
    assign sum[k*CHUNK_W +: CHUNK_W] = t[CHUNK_W-1:0];
    assign carry[k+1] = t[CHUNK_W];
  end

endmodule

// File: rtl/simd_seg_shifter.sv
module simd_seg_shifter #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 6,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int LW_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [LW_W-1:0]   lane_w,
  input  logic              go_left,
  input  logic              arith,
  output logic [DATA_W-1:0] shifted
);

  always_comb begin
    int lw, c, base, pos;
    logic fill;
    lw = int'(lane_w);
    c  = int'(cnt);
    for (int i = 0; i < DATA_W; i++) begin
      pos  = i & (lw - 1);
      base = i - pos;
      fill = arith & data[IDX_W'(base + lw - 1)];
      if (go_left) begin
        if (c >= lw || pos < c) shifted[i] = 1'b0;
        else                    shifted[i] = data[IDX_W'(i - c)];
      end else begin
        if (c >= lw || pos + c >= lw) shifted[i] = fill;
        else                          shifted[i] = data[IDX_W'(i + c)];
      end
    end
  end

endmodule

// File: rtl/simd_packed_alu.sv
module simd_packed_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  parameter int CNT_W   = 6,
  localparam int NCHUNK = DATA_W / CHUNK_W,
  localparam int LW_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [1:0]        lane_mode,
  input  logic [2:0]        op_code,
  input  logic [CNT_W-1:0]  shamt,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_error
);

  logic [NCHUNK-1:0] lane_start;
  logic [LW_W-1:0]   lane_w;
  logic              req_err;
  logic [DATA_W-1:0] add_res;
  logic [DATA_W-1:0] shf_res;
  logic [DATA_W-1:0] next_res;

  simd_lane_ctrl #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_ctrl (
    .lane_mode (lane_mode),
    .op_code   (op_code),
    .lane_start(lane_start),
    .lane_w    (lane_w),
    .req_err   (req_err)
  );

  simd_seg_adder #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_add (
    .a         (opnd_a),
    .b         (opnd_b),
    .sub       (op_code == OP_SUB),
    .lane_start(lane_start),
    .sum       (add_res)
  );

  simd_seg_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
    .data   (opnd_a),
    .cnt    (shamt),
    .lane_w (lane_w),
    .go_left(op_code == OP_SHL),
    .arith  (op_code == OP_SAR),
    .shifted(shf_res)
  );

  always_comb begin
    if (req_err)                                       next_res = '0;
    else if (op_code == OP_ADD || op_code == OP_SUB)   next_res = add_res;
    else                                               next_res = shf_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_error  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= next_res;
        out_error  <= req_err;
      end
    end
  end

endmodule

// File: rtl/simd_packed_alu_chk.sv
module simd_packed_alu_chk #(
  parameter int DATA_W  = 64,
  parameter int CHUNK_W = 8,
  localparam int NCHUNK = DATA_W / CHUNK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        lane_mode,
  input logic [NCHUNK-1:0] lane_start,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_result,
  input logic              out_error
);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_error)));

  // R8
  rsv_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_mode == 2'b11) |=> (out_error && out_result == '0));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_error |-> (out_result == '0));

  // R2
  lane_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_mode != 2'b11) |-> ($countones(lane_start) == (NCHUNK >> lane_mode)));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_error));

endmodule

bind simd_packed_alu simd_packed_alu_chk #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .lane_mode (lane_mode),
  .lane_start(lane_start),
  .out_valid (out_valid),
  .out_result(out_result),
  .out_error (out_error)
);

// File: tb/simd_packed_alu_test.sv
module simd_packed_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [1:0]  lane_mode = '0;
  logic [2:0]  op_code = '0;
  logic [5:0]  shamt = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_error;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  simd_packed_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .lane_mode(lane_mode),
    .op_code(op_code), .shamt(shamt),
    .out_valid(out_valid), .out_result(out_result), .out_error(out_error)
  );

  // Independent lane model: extract each lane, compute at full width, mask back.
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] m, input logic [2:0] op,
                                        input int cnt);
    logic [63:0] res, msk, la, lb, r;
    logic signed [63:0] sx;
    int w;
    if (m == 2'b11 || op > 3'd4) return 64'd0;
    w   = 8 * (1 << m);
    msk = (64'd1 << w) - 64'd1;
    res = '0;
    for (int l = 0; l < 64 / w; l++) begin
      la = (a >> (l * w)) & msk;
      lb = (b >> (l * w)) & msk;
      case (op)
        3'd0: r = la + lb;
        3'd1: r = la - lb;
        3'd2: r = (cnt >= w) ? 64'd0 : (la << cnt);
        3'd3: r = (cnt >= w) ? 64'd0 : (la >> cnt);
        default: begin
          sx = $signed(la << (64 - w)) >>> (64 - w);
          r  = 64'(sx >>> cnt);
        end
      endcase
      res = res | ((r & msk) << (l * w));
    end
    return res;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // One request; result checked at the falling edge after the capturing edge.
  task automatic apply(input string req, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] m, input logic [2:0] op, input int cnt);
    @(negedge clk);
    opnd_a = a; opnd_b = b; lane_mode = m; op_code = op; shamt = 6'(cnt);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "result", out_result, model(a, b, m, op, cnt));
    check(req, "error", {63'd0, out_error}, {63'd0, (m == 2'b11 || op > 3'd4)});
  endtask

  task automatic t_reset();
    check("R11", "valid after reset", {63'd0, out_valid}, 64'd0);
    check("R11", "result after reset", out_result, 64'd0);
    check("R11", "error after reset", {63'd0, out_error}, 64'd0);
  endtask

  task automatic t_add8();
    apply("R1", 64'hFF01_7F80_1234_00FF, 64'h0102_0180_FFFF_0101, 2'b00, 3'd0, 0);
    apply("R1", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'b00, 3'd0, 0);
  endtask

  task automatic t_add_wide();
    apply("R2", 64'h00FF_FFFF_8000_7FFF, 64'h0001_0001_8000_0001, 2'b01, 3'd0, 0);
    apply("R2", 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'b10, 3'd0, 0);
    apply("R2", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'b00, 3'd0, 0);
  endtask

  task automatic t_sub();
    apply("R3", 64'h0000_0100_0005_1234, 64'h0001_0001_0006_1234, 2'b00, 3'd1, 0);
    apply("R3", 64'h0000_0000_0001_0000, 64'h0000_0001_0002_0001, 2'b01, 3'd1, 0);
    apply("R3", 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b10, 3'd1, 0);
  endtask

  task automatic t_shl();
    apply("R4", 64'h8181_8181_F00F_0FF0, 64'd0, 2'b00, 3'd2, 3);
    apply("R4", 64'h8001_4003_FFFF_1234, 64'd0, 2'b01, 3'd2, 5);
    apply("R4", 64'hC000_0001_8765_4321, 64'd0, 2'b10, 3'd2, 17);
  endtask

  task automatic t_shr();
    apply("R5", 64'h8181_8181_F00F_0FF0, 64'd0, 2'b00, 3'd3, 3);
    apply("R5", 64'h8001_4003_FFFF_1234, 64'd0, 2'b01, 3'd3, 9);
    apply("R5", 64'hC000_0001_8765_4321, 64'd0, 2'b10, 3'd3, 31);
  endtask

  task automatic t_sar();
    apply("R6", 64'h8171_80FF_7F01_C33C, 64'd0, 2'b00, 3'd4, 2);
    apply("R6", 64'h8001_7FFF_FFFF_0F0F, 64'd0, 2'b01, 3'd4, 15);
    apply("R6", 64'h8000_0001_7654_3210, 64'd0, 2'b10, 3'd4, 4);
  endtask

  task automatic t_big_count();
    apply("R7", 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b00, 3'd2, 8);
    apply("R7", 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 2'b01, 3'd3, 40);
    apply("R7", 64'h8000_7FFF_8000_7FFF, 64'd0, 2'b01, 3'd4, 16);
    apply("R7", 64'h8000_0000_7FFF_FFFF, 64'd0, 2'b10, 3'd4, 63);
    apply("R7", 64'h8080_7F7F_8080_7F7F, 64'd0, 2'b00, 3'd4, 7);
  endtask

  task automatic t_reserved();
    apply("R8", 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 2'b11, 3'd0, 0);
    apply("R8", 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, 2'b00, 3'd6, 0);
    apply("R8", 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b00, 3'd0, 0);
  endtask

  task automatic t_timing_hold();
    logic [63:0] exp;
    exp = model(64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 2'b00, 3'd0, 0);
    @(negedge clk);
    opnd_a = 64'h0102_0304_0506_0708; opnd_b = 64'h1010_1010_1010_1010;
    lane_mode = 2'b00; op_code = 3'd0; shamt = '0; in_valid = 1'b1;
    check("R9", "valid before edge", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R9", "valid one cycle on", {63'd0, out_valid}, 64'd1);
    check("R9", "result one cycle on", out_result, exp);
    in_valid = 1'b0;
    opnd_a = 64'hFFFF_FFFF_FFFF_FFFF; lane_mode = 2'b11; op_code = 3'd7;
    @(negedge clk);
    check("R9", "valid drops", {63'd0, out_valid}, 64'd0);
    check("R10", "result held", out_result, exp);
    check("R10", "error held", {63'd0, out_error}, 64'd0);
    @(negedge clk);
    check("R10", "result still held", out_result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add8();
    t_add_wide();
    t_sub();
    t_shl();
    t_shr();
    t_sar();
    t_big_count();
    t_reserved();
    t_timing_hold();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule